// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate with Timeout

This block sits between a host register port and an external byte-wide peer channel. It serves the enhanced-mode address and data offsets of a parallel port. A host access at one of these offsets becomes one or more byte transfers on the peer channel. The block owns the port's control register, and each transfer first checks that register. Writes run only with the write line pattern, and reads run only with the read line pattern. Any other access at these offsets is dropped. A dropped read returns all ones.

Data accesses can be 8, 16 or 32 bits wide. The block splits them into byte transfers, lowest byte first. Each byte uses a request/acknowledge handshake. A cycle counter limits how long the block waits for the peer. If the peer misses the limit, the block sets a sticky timeout flag and ends the access at once. Any bytes that were never transferred read back as all ones. The flag appears in bit 0 of the status register, in place of the external bit 0. Only a status write with bit 0 set clears it.

The host sees a single busy/ready exchange. It holds `host_valid` and its access fields until `host_ready` pulses for one cycle. `host_rdata` is valid during that pulse. The controller has three states:
- `ST_IDLE` accepts an access. It goes to `ST_XFER` when the access is an enhanced-mode cycle that passes the gate, and to `ST_DONE` for every other access.
- `ST_XFER` drives one byte request. It stays there while further bytes remain. It goes to `ST_DONE` on the acknowledge of the last byte or when the wait limit expires.
- `ST_DONE` raises `host_ready` and always returns to `ST_IDLE`.

Top module: `epp_cycle_unit`

## Requirements
- R1: After reset, the control register reads 0xCC, the timeout flag is 0 and `chan_req` is low.
- R2: A write at offset 2 stores the written byte with bits 7:6 forced to 1. The stored value drives `ctl_lines` and reads back at offset 2 in `host_rdata[7:0]`, with bits 31:8 zero.
- R3: A read at offset 1 returns `{ext_status[7:1], timeout_flag}` in bits 7:0, with bits 31:8 zero.
- R4: A write at offset 3 or 4 starts transfers only when `(control & 0x2F) == 0x04`. Bit 5 is direction, bit 3 is select-in, bit 2 is init, bit 1 is auto-linefeed and bit 0 is strobe. Otherwise the write is dropped: no `chan_req`, and the flag is unchanged.
- R5: A read at offset 3 or 4 starts transfers only when `(control & 0x2F) == 0x24`. Otherwise no `chan_req` is raised and `host_rdata` is 0xFFFFFFFF.
- R6: Offset 3 transfers exactly one byte with `chan_addr_cyc`=1, whatever the size. Offset 4 transfers with `chan_addr_cyc`=0. `chan_write`, `chan_addr_cyc` and `chan_wdata` hold steady while a byte waits for its acknowledge.
- R7: At offset 4, `host_size` 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 moves 4 bytes. Bytes move least significant first. Write bytes come from `host_wdata` lanes. Read bytes fill `host_rdata` lanes in the same order, and unused lanes read 0xFF.
- R8: A byte with no `chan_ack` for TMO_CYCLES consecutive request cycles is a timeout. The flag is set, the rest of the access is abandoned, and the lanes not received read 0xFF.
- R9: The timeout flag is sticky. A status write with bit 0 set clears it. A status write with bit 0 clear, or any later successful transfer, leaves it unchanged.
- R10: `host_ready` is high for exactly one cycle per access and never together with `chan_req`. A non-transfer access completes with `host_ready` in the cycle after acceptance.
- R11: Reads at offsets 0, 5, 6 and 7 return 0xFFFFFFFF, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request, held until ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Access width code (0 byte, 1 half, 2/3 word) |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| ctl_lines | output | 8 | Current control register value |
| ext_status | input | 8 | Status lines from the port |
| chan_req | output | 1 | Byte transfer request |
| chan_addr_cyc | output | 1 | 1 = address cycle, 0 = data cycle |
| chan_write | output | 1 | 1 = byte to peer, 0 = byte from peer |
| chan_wdata | output | 8 | Byte to peer |
| chan_ack | input | 1 | Peer acknowledge of the current byte |
| chan_rdata | input | 8 | Byte from peer, valid with chan_ack |

## Verification
The bench sets control values one bit away from each gate pattern, such as strobe or auto-linefeed set, and values with ungated bits added. A gate that compares too few or too many bits would then start transfers that must be dropped, or drop ones that must run. It lets the peer stall at the first, middle and last byte of wide reads. A design that keeps going after a timeout would show extra peer bytes. A design that zero-fills the missing lanes would return the wrong read data. It also writes bit 0 clear to the status register and runs successful transfers after a timeout, which catches a flag that is not sticky or that clears on the wrong value. It counts request cycles exactly, so an off-by-one wait limit changes the count.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;

    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_ADDR = 3'd3;
    localparam logic [2:0] OFS_DATA = 3'd4;

    // control bits examined by the gate: direction, select-in, init, autofeed, strobe
    localparam logic [7:0] CTL_GATE_MASK = 8'h2F;
    localparam logic [7:0] CTL_WR_PAT    = 8'h04;
    localparam logic [7:0] CTL_RD_PAT    = 8'h24;
    localparam logic [7:0] CTL_FIXED     = 8'hC0;
    localparam logic [7:0] CTL_RESET     = 8'hCC;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } epp_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } epp_size_e;

endpackage

// File: rtl/epp_ctl_gate.sv
module epp_ctl_gate
    import epp_gate_pkg::*;
(
    input  logic [7:0] ctl,
    output logic       wr_ok,
    output logic       rd_ok
);
    logic [7:0] masked;

    always_comb begin
        masked = ctl & CTL_GATE_MASK;
        wr_ok  = (masked == CTL_WR_PAT);
        rd_ok  = (masked == CTL_RD_PAT);
    end
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int TMO_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYCLES + 1) + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CW'(TMO_CYCLES - 1));
endmodule

// File: rtl/epp_state_regs.sv
module epp_state_regs
    import epp_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       flag_set,
    input  logic       flag_clr,
    output logic [7:0] ctl,
    output logic       tmo_flag
);
    logic [7:0] ctl_q;
    logic       flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata | CTL_FIXED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (flag_set) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign ctl      = ctl_q;
    assign tmo_flag = flag_q;
endmodule

// File: rtl/epp_cycle_unit.sv
module epp_cycle_unit
    import epp_gate_pkg::*;
#(
    parameter int HOST_W     = 32,
    parameter int TMO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [2:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [HOST_W-1:0] host_rdata,
    output logic [7:0]        ctl_lines,
    input  logic [7:0]        ext_status,
    output logic              chan_req,
    output logic              chan_addr_cyc,
    output logic              chan_write,
    output logic [7:0]        chan_wdata,
    input  logic              chan_ack,
    input  logic [7:0]        chan_rdata
);
    localparam int LANES = HOST_W / 8;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    epp_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q, last_q, last_sel;
    logic              op_wr_q, op_acyc_q;
    logic [HOST_W-1:0] wbuf_q, rbuf_q, rd_value;

    logic [7:0] ctl;
    logic       tmo_flag, wr_ok, rd_ok, expired;
    logic       accept, is_epp, gate_ok, start_xfer;
    logic       byte_done, last_byte, tmo_hit;
    logic       ctl_we, flag_clr;

    epp_ctl_gate u_gate (
        .ctl   (ctl),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok)
    );

    epp_wait_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q != ST_XFER) || chan_ack),
        .run     (state_q == ST_XFER),
        .expired (expired)
    );

    epp_state_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (host_wdata[7:0]),
        .flag_set  (tmo_hit),
        .flag_clr  (flag_clr),
        .ctl       (ctl),
        .tmo_flag  (tmo_flag)
    );

    // access decode
    always_comb begin
        accept     = (state_q == ST_IDLE) && host_valid;
        is_epp     = (host_addr == OFS_ADDR) || (host_addr == OFS_DATA);
        gate_ok    = host_write ? wr_ok : rd_ok;
        start_xfer = accept && is_epp && gate_ok;
        ctl_we     = accept && host_write && (host_addr == OFS_CTRL);
        flag_clr   = accept && host_write && (host_addr == OFS_STAT) && host_wdata[0];
        byte_done  = (state_q == ST_XFER) && chan_ack;
        last_byte  = (idx_q == last_q);
        tmo_hit    = (state_q == ST_XFER) && !chan_ack && expired;
    end

    // byte count of the access, as last lane index
    always_comb begin
        last_sel = '0;
        if (host_addr == OFS_DATA) begin
            unique case (epp_size_e'(host_size))
                SZ_BYTE: last_sel = '0;
                SZ_HALF: last_sel = (LANES > 1) ? IDX_W'(1) : '0;
                SZ_WORD,
                SZ_WIDE: last_sel = IDX_W'(LANES - 1);
            endcase
        end
    end

    // immediate read value of a non-transfer access
    always_comb begin
        rd_value = '1;
        if (host_write) begin
            rd_value = '0;
        end else if (host_addr == OFS_STAT) begin
            rd_value = HOST_W'({ext_status[7:1], tmo_flag});
        end else if (host_addr == OFS_CTRL) begin
            rd_value = HOST_W'(ctl);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_xfer) begin
                    state_d = ST_XFER;
                end else if (accept) begin
                    state_d = ST_DONE;
                end
            end
            ST_XFER: begin
                if ((byte_done && last_byte) || tmo_hit) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_ready    = (state_q == ST_DONE);
        host_rdata    = rbuf_q;
        chan_req      = (state_q == ST_XFER);
        chan_write    = op_wr_q;
        chan_addr_cyc = op_acyc_q;
        chan_wdata    = wbuf_q[7:0];
        ctl_lines     = ctl;
    end

    // transfer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            last_q    <= '0;
            op_wr_q   <= 1'b0;
            op_acyc_q <= 1'b0;
            wbuf_q    <= '0;
            rbuf_q    <= '1;
        end else if (accept) begin
            idx_q     <= '0;
            last_q    <= last_sel;
            op_wr_q   <= host_write;
            op_acyc_q <= (host_addr == OFS_ADDR);
            wbuf_q    <= host_wdata;
            rbuf_q    <= rd_value;
        end else if (byte_done) begin
            idx_q  <= idx_q + 1'b1;
            wbuf_q <= wbuf_q >> 8;
            if (!op_wr_q) begin
                for (int l = 0; l < LANES; l++) begin
                    if (idx_q == IDX_W'(l)) begin
                        rbuf_q[l*8 +: 8] <= chan_rdata;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/epp_cycle_unit_chk.sv
module epp_cycle_unit_chk
    import epp_gate_pkg::*;
#(
    parameter int TMO_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ready,
    input logic [7:0] ctl_lines,
    input logic       chan_req,
    input logic       chan_ack,
    input logic       chan_write,
    input logic       chan_addr_cyc,
    input logic [7:0] chan_wdata
);
    localparam int CW = $clog2(TMO_CYCLES + 2) + 1;

    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (chan_req && !chan_ack) begin
            wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req && chan_write) |-> ((ctl_lines & CTL_GATE_MASK) == CTL_WR_PAT)); // R4
    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req && !chan_write) |-> ((ctl_lines & CTL_GATE_MASK) == CTL_RD_PAT)); // R5
    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req && !chan_ack && (wait_cnt < CW'(TMO_CYCLES - 1)))
        |=> (chan_req && $stable(chan_wdata) && $stable(chan_addr_cyc) && $stable(chan_write))); // R6
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        chan_req |-> (wait_cnt < CW'(TMO_CYCLES))); // R8
    AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req && !chan_ack && (wait_cnt == CW'(TMO_CYCLES - 1))) |=> !chan_req); // R8
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready); // R10
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !chan_req); // R10
endmodule

bind epp_cycle_unit epp_cycle_unit_chk #(.TMO_CYCLES(TMO_CYCLES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_ready    (host_ready),
    .ctl_lines     (ctl_lines),
    .chan_req      (chan_req),
    .chan_ack      (chan_ack),
    .chan_write    (chan_write),
    .chan_addr_cyc (chan_addr_cyc),
    .chan_wdata    (chan_wdata)
);

// File: tb/epp_cycle_unit_tb_top.sv
module epp_cycle_unit_tb_top;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic [7:0]  ctl_lines;
    logic [7:0]  ext_status = 8'h00;
    logic        chan_req, chan_addr_cyc, chan_write;
    logic [7:0]  chan_wdata;
    logic        chan_ack = 1'b0;
    logic [7:0]  chan_rdata = 8'h00;

    always #2 clk = ~clk;

    epp_cycle_unit #(.HOST_W(32), .TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata), .ctl_lines(ctl_lines),
        .ext_status(ext_status), .chan_req(chan_req), .chan_addr_cyc(chan_addr_cyc),
        .chan_write(chan_write), .chan_wdata(chan_wdata), .chan_ack(chan_ack),
        .chan_rdata(chan_rdata)
    );

    int n_chk = 0;
    int n_err = 0;

    // peer model
    int         peer_delay = 0;
    int         peer_budget = 0;
    int         peer_wait = 0;
    int         log_n = 0;
    int         req_cycles = 0;
    logic [7:0] src [4];
    logic [7:0] log_data [8];
    logic       log_acyc [8];
    logic       log_wr [8];

    always @(negedge clk) begin
        if (chan_req) req_cycles++;
        if (chan_ack) begin
            chan_ack  = 1'b0;
            peer_wait = 0;
        end else if (chan_req) begin
            if (peer_budget > 0 && peer_wait >= peer_delay && log_n < 8) begin
                chan_ack           = 1'b1;
                chan_rdata         = src[log_n % 4];
                log_data[log_n]    = chan_wdata;
                log_acyc[log_n]    = chan_addr_cyc;
                log_wr[log_n]      = chan_write;
                log_n++;
                peer_budget--;
            end else begin
                peer_wait++;
            end
        end
    end

    // reference model
    logic [7:0] ctl_m;
    logic       flag_m;
    int         lat;
    logic       ready_after;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit gate_ok(input bit w, input logic [7:0] c);
        return (c & 8'h2F) == (w ? 8'h04 : 8'h24);
    endfunction

    function automatic int nbytes(input logic [2:0] a, input logic [1:0] sz);
        if (a != 3'd4) return 1;
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic access(input bit w, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        int guard = 0;
        @(negedge clk);
        log_n = 0; req_cycles = 0; peer_wait = 0;
        host_valid = 1'b1; host_write = w; host_addr = a; host_size = sz; host_wdata = wd;
        lat = 0;
        rd = 'x;
        forever begin
            @(negedge clk);
            lat++;
            if (host_ready) begin
                rd = host_rdata;
                break;
            end
            guard++;
            if (guard > TMO * 8 + 50) begin
                chk(1'b0, "R10 access hung", 32'(guard), 32'd0);
                break;
            end
        end
        host_valid = 1'b0;
        @(negedge clk);
        ready_after = host_ready;
    endtask

    task automatic ctrl_write(input logic [7:0] v);
        logic [31:0] rd;
        access(1'b1, 3'd2, 2'd0, {24'h0, v}, rd);
        ctl_m = v | 8'hC0;
    endtask

    task automatic status_read(input string tag);
        logic [31:0] rd;
        logic [31:0] exp;
        ext_status = 8'($urandom);
        access(1'b0, 3'd1, 2'd0, 32'h0, rd);
        exp = {24'h0, ext_status[7:1], flag_m};
        chk(rd === exp, tag, rd, exp);
    endtask

    task automatic epp_run(input bit w, input logic [2:0] a, input logic [1:0] sz,
                           input logic [31:0] wd, input int budget, input int delay);
        logic [31:0] rd, exp;
        int n, acked;
        bit g;
        for (int i = 0; i < 4; i++) src[i] = 8'($urandom);
        peer_budget = budget;
        peer_delay  = delay;
        g = gate_ok(w, ctl_m);
        n = nbytes(a, sz);
        acked = g ? ((budget < n) ? budget : n) : 0;
        access(w, a, sz, wd, rd);
        peer_budget = 0;
        chk(log_n == acked, w ? "R4 byte count" : "R5 byte count", 32'(log_n), 32'(acked));
        for (int i = 0; i < acked && i < log_n; i++) begin
            chk(log_acyc[i] === (a == 3'd3), "R6 cycle kind", 32'(log_acyc[i]), 32'(a == 3'd3));
            chk(log_wr[i] === w, "R6 direction", 32'(log_wr[i]), 32'(w));
            if (w) chk(log_data[i] === wd[i*8 +: 8], "R7 write lane order", 32'(log_data[i]), 32'(wd[i*8 +: 8]));
        end
        if (!w) begin
            exp = 32'hFFFF_FFFF;
            for (int i = 0; i < acked; i++) exp[i*8 +: 8] = src[i];
            chk(rd === exp, g ? ((acked < n) ? "R8 partial read" : "R7 read assembly") : "R5 blocked read",
                rd, exp);
        end
        if (g && budget < n) flag_m = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  cv;
        logic [7:0]  choices [8];
        void'($urandom(32'd4242));
        choices[0] = 8'h04; choices[1] = 8'h24; choices[2] = 8'h14; choices[3] = 8'h34;
        choices[4] = 8'h05; choices[5] = 8'h26; choices[6] = 8'h0C; choices[7] = 8'h00;
        ctl_m = 8'hCC; flag_m = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctl_lines === 8'hCC, "R1 ctl_lines", 32'(ctl_lines), 32'hCC);
        chk(chan_req === 1'b0, "R1 chan_req", 32'(chan_req), 32'h0);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd);
        chk(rd === 32'hCC, "R1 control read", rd, 32'hCC);
        chk(lat == 1, "R10 register latency", 32'(lat), 32'd1);
        chk(ready_after === 1'b0, "R10 ready pulse", 32'(ready_after), 32'd0);
        status_read("R1 flag clear at reset");

        // R2 control storage
        ctrl_write(8'h3F);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd);
        chk(rd === 32'hFF, "R2 control readback", rd, 32'hFF);
        ctrl_write(8'h00);
        chk(ctl_lines === 8'hC0, "R2 ctl_lines", 32'(ctl_lines), 32'hC0);

        // R11 unused offsets
        access(1'b0, 3'd0, 2'd0, 32'h0, rd);
        chk(rd === 32'hFFFF_FFFF, "R11 offset 0 read", rd, 32'hFFFF_FFFF);
        access(1'b1, 3'd6, 2'd2, 32'h1234_5678, rd);
        chk(log_n == 0, "R11 no transfer", 32'(log_n), 32'd0);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd);
        chk(rd === 32'hC0, "R11 control untouched", rd, 32'hC0);

        // R4 write gating and R6/R7 transfers
        ctrl_write(8'h04);
        epp_run(1'b1, 3'd3, 2'd2, 32'hAABB_CC5A, 4, 0);   // R6 address offset is one byte
        epp_run(1'b1, 3'd4, 2'd2, 32'h4433_2211, 4, 1);   // R7 word write
        epp_run(1'b1, 3'd4, 2'd1, 32'h0000_BEEF, 4, 0);   // R7 half write
        epp_run(1'b0, 3'd4, 2'd2, 32'h0, 4, 0);           // R5 read blocked in write mode
        ctrl_write(8'h05);                                 // R4 strobe set: blocked
        epp_run(1'b1, 3'd4, 2'd0, 32'h0000_0077, 4, 0);
        ctrl_write(8'h06);                                 // R4 autofeed set: blocked
        epp_run(1'b1, 3'd3, 2'd0, 32'h0000_0077, 4, 0);
        ctrl_write(8'h14);                                 // R4 ungated bit 4 allowed
        epp_run(1'b1, 3'd4, 2'd0, 32'h0000_0099, 4, 0);

        // R5 read gating
        ctrl_write(8'h24);
        epp_run(1'b0, 3'd4, 2'd2, 32'h0, 4, 2);
        epp_run(1'b0, 3'd4, 2'd1, 32'h0, 4, 0);
        epp_run(1'b0, 3'd3, 2'd3, 32'h0, 4, 0);
        epp_run(1'b1, 3'd4, 2'd0, 32'h0000_0011, 4, 0);   // R4 write blocked in read mode
        ctrl_write(8'h2C);                                 // R5 select-in set: blocked
        epp_run(1'b0, 3'd4, 2'd2, 32'h0, 4, 0);
        status_read("R4 dropped access leaves flag");

        // R8 timeout in the middle of a word read
        ctrl_write(8'h24);
        epp_run(1'b0, 3'd4, 2'd2, 32'h0, 2, 0);
        chk(req_cycles == 3 + TMO, "R8 wait limit", 32'(req_cycles), 32'(3 + TMO));
        status_read("R8 flag set");
        // R8 single dead byte
        epp_run(1'b0, 3'd3, 2'd0, 32'h0, 0, 0);
        chk(req_cycles == TMO, "R8 dead byte", 32'(req_cycles), 32'(TMO));

        // R9 stickiness
        access(1'b1, 3'd1, 2'd0, 32'h0000_00FE, rd);
        status_read("R9 bit0 clear keeps flag");
        epp_run(1'b0, 3'd4, 2'd2, 32'h0, 4, 0);
        status_read("R9 success keeps flag");
        access(1'b1, 3'd1, 2'd0, 32'h0000_0001, rd);
        flag_m = 1'b0;
        status_read("R9 flag cleared");

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 7);
            case (op)
                0: begin
                    cv = ($urandom % 4 == 0) ? 8'($urandom) : choices[$urandom % 8];
                    ctrl_write(cv);
                end
                1, 2, 3: begin
                    int bud;
                    bud = ($urandom % 6 == 0) ? int'($urandom % 4) : 4;
                    epp_run(1'($urandom), ($urandom % 2 == 0) ? 3'd3 : 3'd4, 2'($urandom),
                            $urandom, bud, int'($urandom % 3));
                end
                4: status_read("R3 status read");
                5: begin
                    logic [31:0] wv;
                    wv = $urandom;
                    access(1'b1, 3'd1, 2'd0, wv, rd);
                    if (wv[0]) flag_m = 1'b0;
                end
                default: begin
                    access(1'b0, 3'd2, 2'd0, 32'h0, rd);
                    chk(rd === {24'h0, ctl_m}, "R2 control random", rd, {24'h0, ctl_m});
                end
            endcase
        end
        status_read("R9 final flag");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule